// File: doc/BRIEF.md
# Timer Count-Enable Selector with Free-Running Prescaler

This block produces the count-enable strobe for an 8-bit timer/counter. A 3-bit mode code picks the source of that strobe: nothing, every system clock cycle, one of four divided taps of a 10-bit prescaler that runs all the time, or a rising or falling edge seen on an asynchronous external clock pin. The strobe is always a single system-cycle pulse in the system clock domain, so the counter that consumes it only ever sees a synchronous enable.

The prescaler keeps counting whatever mode is selected. Software can clear it with a one-cycle strobe to line the timer up with a known moment. The external pin is captured on the falling system clock edge and then re-registered on the rising edge, which gives a fixed window of 2.5 to 3.5 system cycles from a pin edge to the counter update. The synchronised pin level is also brought out.

Top module: `tcs_clk_select`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block is cleared: after that edge `cnt_en` and `pin_sync` are 0, the prescaler count is 0 and the edge history is 0.
- R2: Mode code 0 (stop) gives `cnt_en` = 0 in the cycle after it is sampled, whatever the pin and prescaler do.
- R3: Mode code 1 gives `cnt_en` = 1 in the cycle after it is sampled, so the timer counts on every system cycle.
- R4: Mode codes 2, 3, 4 and 5 select division by 8, 64, 256 and 1024. In each, `cnt_en` is high for exactly one cycle each time the low log2(N) prescaler bits wrap, so pulses are exactly N cycles apart.
- R5: The prescaler ignores the mode code. The first pulse after a switch into a divided mode comes between 1 and N+1 cycles after the switch.
- R6: When `psc_clr` is high at a rising edge, the prescaler is 0 after that edge. In a divided mode the first pulse after that edge comes exactly N cycles later.
- R7: Mode code 7 gives exactly one `cnt_en` pulse for each rising edge of the synchronised pin and none otherwise.
- R8: Mode code 6 gives exactly one `cnt_en` pulse for each falling edge of the synchronised pin and none otherwise.
- R9: From a pin edge to the rising clock edge at which the counter takes the matching pulse, 2.5 to 3.5 system cycles pass.
- R10: `pin_sync` equals the pin value captured at the previous falling clock edge, re-registered on the rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_code | input | 3 | Mode code: 0 stop, 1 every cycle, 2..5 divide by 8/64/256/1024, 6 pin falling, 7 pin rising |
| psc_clr | input | 1 | One-cycle strobe that clears the prescaler |
| ext_pin | input | 1 | Asynchronous external clock pin |
| cnt_en | output | 1 | Single-cycle count enable for the timer |
| pin_sync | output | 1 | Synchronised external pin level |

## Verification
On every cycle the assertions check the reset values, the stop and every-cycle modes, and that in the two pin modes a pulse follows each matching edge of `pin_sync` and never appears without one. The divide ratios, the 1 to N+1 first-count window over several prescaler phases, the exact delay after a prescaler clear and the 2.5 to 3.5 cycle pin latency depend on history or on timing within a half cycle. Only the bench's scenarios and its cycle-by-cycle model show those.

// File: rtl/tcs_pkg.sv
// Shared constants and the mode encoding of the timer count-enable selector.
// Assumes the divided taps are powers of two and fit inside the prescaler.
package tcs_pkg;
    localparam int PSC_W  = 10;
    localparam int N_TAPS = 4;
    // log2 of each divided tap, in mode-code order starting at code 2
    localparam int TAP_LOG2 [N_TAPS] = '{3, 6, 8, 10};

    typedef enum logic [2:0] {
        CS_STOP     = 3'd0,
        CS_SYS      = 3'd1,
        CS_DIV8     = 3'd2,
        CS_DIV64    = 3'd3,
        CS_DIV256   = 3'd4,
        CS_DIV1024  = 3'd5,
        CS_EXT_FALL = 3'd6,
        CS_EXT_RISE = 3'd7
    } cs_mode_e;
endpackage

// File: rtl/tcs_prescaler.sv
// Free-running prescaler. It counts every cycle whatever the mode is.
// Each tap is high in the cycle where its low bits are all ones, which is
// the cycle just before they wrap to zero. Assumes TAP_LOG2 entries <= W.
module tcs_prescaler
    import tcs_pkg::*;
#(
    parameter int W  = PSC_W,
    parameter int NT = N_TAPS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [NT-1:0] tap
);
    logic [W-1:0] cnt_q;

    // Count up every cycle; reset or software clear returns to zero
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
    end

    // One wrap detector per divided tap
    for (genvar g = 0; g < NT; g++) begin : g_tap
        localparam int LB = TAP_LOG2[g];
        assign tap[g] = &cnt_q[LB-1:0];
    end
endmodule

// File: rtl/tcs_pin_sync.sv
// External pin synchroniser and edge detector. The pin is captured on the
// falling clock edge, which stands in for a latch open during the high
// phase, then re-registered on the rising edge. The edge history is
// compared with the synchronised level. Assumes each pin half period is
// longer than one system cycle.
module tcs_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_s,
    output logic rise,
    output logic fall
);
    logic cap_q;
    logic sync_q;
    logic hist_q;

    // Half-cycle capture of the asynchronous pin
    always_ff @(negedge clk) begin
        if (!rst_n) cap_q <= 1'b0;
        else        cap_q <= pin_async;
    end

    // Rising-edge synchroniser stage and edge history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 1'b0;
            hist_q <= 1'b0;
        end else begin
            sync_q <= cap_q;
            hist_q <= sync_q;
        end
    end

    assign pin_s = sync_q;
    assign rise  = sync_q & ~hist_q;
    assign fall  = ~sync_q & hist_q;
endmodule

// File: rtl/tcs_clk_select.sv
// Top of the timer count-enable selector. It muxes the stop, every-cycle,
// prescaler-tap and pin-edge sources by mode code and registers the result
// into a single-cycle enable. Assumes cs_code is synchronous to clk.
module tcs_clk_select
    import tcs_pkg::*;
#(
    parameter int PSC_BITS = PSC_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] cs_code,
    input  logic       psc_clr,
    input  logic       ext_pin,
    output logic       cnt_en,
    output logic       pin_sync
);
    localparam int NT = N_TAPS;

    logic [NT-1:0] tap;
    logic          pin_rise;
    logic          pin_fall;
    logic          pick;
    logic          en_q;

    tcs_prescaler #(.W(PSC_BITS), .NT(NT)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (psc_clr),
        .tap   (tap)
    );

    tcs_pin_sync u_pin (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (ext_pin),
        .pin_s     (pin_sync),
        .rise      (pin_rise),
        .fall      (pin_fall)
    );

    // Select the enable source named by the mode code
    always_comb begin
        unique case (cs_mode_e'(cs_code))
            CS_STOP:     pick = 1'b0;
            CS_SYS:      pick = 1'b1;
            CS_DIV8:     pick = tap[0];
            CS_DIV64:    pick = tap[1];
            CS_DIV256:   pick = tap[2];
            CS_DIV1024:  pick = tap[3];
            CS_EXT_FALL: pick = pin_fall;
            CS_EXT_RISE: pick = pin_rise;
            default:     pick = 1'b0;
        endcase
    end

    // Register the chosen source into the count enable
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= pick;
    end

    assign cnt_en = en_q;
endmodule

// File: rtl/tcs_checks.sv
// Cycle-level properties of the count-enable selector, bound to the top.
module tcs_checks (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] cs_code,
    input logic       cnt_en,
    input logic       pin_sync
);
    // R1: outputs are cleared by reset
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!cnt_en && !pin_sync));

    // R2: stop mode never enables
    assert_stop_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_code == 3'd0) |=> !cnt_en);

    // R3: every-cycle mode always enables
    assert_every_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_code == 3'd1) |=> cnt_en);

    // R7: a rising pin edge gives a pulse
    assert_rise_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_code == 3'd7 && $rose(pin_sync)) |=> cnt_en);

    // R7: no pulse without a rising pin edge
    assert_rise_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_code == 3'd7 && !$rose(pin_sync)) |=> !cnt_en);

    // R8: a falling pin edge gives a pulse
    assert_fall_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_code == 3'd6 && $fell(pin_sync)) |=> cnt_en);

    // R8: no pulse without a falling pin edge
    assert_fall_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_code == 3'd6 && !$fell(pin_sync)) |=> !cnt_en);
endmodule

bind tcs_clk_select tcs_checks u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_code  (cs_code),
    .cnt_en   (cnt_en),
    .pin_sync (pin_sync)
);

// File: tb/tb_tcs_clk_select.sv
`timescale 1ns/1ps
module tb_tcs_clk_select;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cs_code = 3'd0;
    logic       psc_clr = 1'b0;
    logic       ext_pin = 1'b0;
    logic       cnt_en;
    logic       pin_sync;

    int n_cmp = 0;
    int n_bad = 0;

    tcs_clk_select dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_code  (cs_code),
        .psc_clr  (psc_clr),
        .ext_pin  (ext_pin),
        .cnt_en   (cnt_en),
        .pin_sync (pin_sync)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Behavioural reference model
    int    m_psc  = 0;
    bit    m_cap  = 0;
    bit    m_sync = 0;
    bit    m_prev = 0;
    bit    m_tick = 0;
    string m_req  = "R1";

    always @(negedge clk) m_cap = rst_n ? ext_pin : 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_psc = 0; m_sync = 0; m_prev = 0; m_tick = 0; m_req = "R1";
        end else begin
            case (cs_code)
                3'd0: begin m_tick = 0; m_req = "R2"; end
                3'd1: begin m_tick = 1; m_req = "R3"; end
                3'd2: begin m_tick = (m_psc % 8) == 7;       m_req = "R4"; end
                3'd3: begin m_tick = (m_psc % 64) == 63;     m_req = "R4"; end
                3'd4: begin m_tick = (m_psc % 256) == 255;   m_req = "R4"; end
                3'd5: begin m_tick = (m_psc % 1024) == 1023; m_req = "R4"; end
                3'd6: begin m_tick = !m_sync && m_prev;      m_req = "R8"; end
                default: begin m_tick = m_sync && !m_prev;   m_req = "R7"; end
            endcase
            m_prev = m_sync;
            m_sync = m_cap;
            m_psc  = psc_clr ? 0 : (m_psc + 1) % 1024;
        end
        #1;
        chk(cnt_en === m_tick, m_req, int'(cnt_en), int'(m_tick));
        chk(pin_sync === m_sync, "R10", int'(pin_sync), int'(m_sync));
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #2;
    endtask

    // R4: pulses exactly N cycles apart
    task automatic period_check(input logic [2:0] code, input int n);
        int k;
        cs_code = code;
        do begin @(posedge clk); #1; end while (!cnt_en);
        for (int p = 0; p < 2; p++) begin
            k = 0;
            do begin @(posedge clk); #1; k++; end while (!cnt_en);
            chk(k == n, "R4 period", k, n);
        end
        #1;
    endtask

    // R5: first pulse after entering a divided mode within 1..N+1 cycles
    task automatic first_count(input logic [2:0] code, input int n, input int wait_c);
        int k = 0;
        cs_code = 3'd0;
        cyc(wait_c + 1);
        cs_code = code;
        do begin @(posedge clk); #1; k++; end while (!cnt_en && k < n + 3);
        chk(k >= 1 && k <= n + 1, "R5 first count", k, n);
        #1;
        cs_code = 3'd0;
    endtask

    // R6: after a clear the first pulse comes exactly N cycles later
    task automatic clear_check(input logic [2:0] code, input int n, input int wait_c);
        int k = 0;
        cs_code = code;
        cyc(wait_c + 1);
        psc_clr = 1'b1;
        @(posedge clk); #2;
        psc_clr = 1'b0;
        do begin @(posedge clk); #1; k++; end while (!cnt_en && k < n + 3);
        chk(k == n, "R6 after clear", k, n);
        #1;
    endtask

    // R9: pin edge to counter update within 25..35 ns
    task automatic latency_check(input logic [2:0] code, input bit lvl, input int ofs, input string req);
        int  t0;
        int  lat = -1;
        cs_code = code;
        ext_pin = ~lvl;
        cyc(6);
        @(posedge clk); #(ofs);
        ext_pin = lvl;
        t0 = $time;
        for (int i = 0; i < 8 && lat < 0; i++) begin
            @(posedge clk); #1;
            if (cnt_en) lat = $time - 1 + 10 - t0;
        end
        chk(lat >= 25 && lat <= 35, "R9 latency", lat, 30);
        chk(lat > 0, req, lat, 30);
        cyc(4);
    endtask

    // R7/R8: one pulse per matching edge over a pin waveform
    task automatic edge_count(input logic [2:0] code, input int edges, input string req);
        int got = 0;
        cs_code = code;
        ext_pin = 1'b0;
        cyc(6);
        for (int e = 0; e < 2 * edges; e++) begin
            ext_pin = ~ext_pin;
            for (int c = 0; c < 3; c++) begin
                @(posedge clk); #1;
                if (cnt_en) got++;
            end
            #1;
        end
        for (int c = 0; c < 5; c++) begin @(posedge clk); #1; if (cnt_en) got++; end
        chk(got == edges, req, got, edges);
        #1;
    endtask

    initial begin
        #200_000_0;
        $display("FAIL watchdog expired");
        n_bad++;
        summary();
    end

    initial begin
        int ones;
        cyc(3);
        chk(cnt_en === 1'b0, "R1 reset enable", int'(cnt_en), 0);
        chk(pin_sync === 1'b0, "R1 reset pin", int'(pin_sync), 0);
        rst_n = 1'b1;

        // R2: stop mode with a toggling pin
        cs_code = 3'd0;
        for (int i = 0; i < 20; i++) begin ext_pin = ~ext_pin; cyc(2); end
        chk(cnt_en === 1'b0, "R2 stop", int'(cnt_en), 0);

        // R3: every cycle
        cs_code = 3'd1;
        ones = 0;
        for (int i = 0; i < 10; i++) begin @(posedge clk); #1; if (cnt_en) ones++; end
        chk(ones == 9 || ones == 10, "R3 every cycle", ones, 10);
        #1;

        period_check(3'd2, 8);
        period_check(3'd3, 64);
        period_check(3'd4, 256);
        period_check(3'd5, 1024);

        for (int w = 0; w < 10; w++) first_count(3'd2, 8, w);
        first_count(3'd3, 64, 5);
        first_count(3'd3, 64, 40);
        first_count(3'd4, 256, 100);

        clear_check(3'd2, 8, 3);
        clear_check(3'd3, 64, 20);
        clear_check(3'd5, 1024, 7);

        latency_check(3'd7, 1'b1, 2, "R7 rise pulse");
        latency_check(3'd7, 1'b1, 7, "R7 rise pulse");
        latency_check(3'd6, 1'b0, 2, "R8 fall pulse");
        latency_check(3'd6, 1'b0, 7, "R8 fall pulse");

        edge_count(3'd7, 5, "R7 rising count");
        edge_count(3'd6, 5, "R8 falling count");

        // R1: reset mid-run clears outputs
        cs_code = 3'd1;
        ext_pin = 1'b1;
        cyc(5);
        rst_n = 1'b0;
        cyc(2);
        chk(cnt_en === 1'b0, "R1 reset again", int'(cnt_en), 0);
        chk(pin_sync === 1'b0, "R1 reset pin again", int'(pin_sync), 0);
        rst_n = 1'b1;
        cyc(5);
        summary();
    end
endmodule